// File: doc/BRIEF.md
# Run-Time Programmable Binary Field Multiplier

This unit multiplies two binary polynomials and reduces the product modulo a polynomial g(x) whose degree m and lower coefficients are both given with each request. The same sequential datapath also yields the three plain carry-less products of two XLEN-bit words: the low word, the high word, and the word taken one bit below the high word. A carry-less product is the field product with modulus x^m and no reduction step.

A request is made by raising `start_i` for one cycle while the unit is idle, with the operands, degree, modulus and operation select held valid in that cycle. The unit captures them and then walks the second operand one bit per cycle from its most significant bit down, doing a shift, an optional reduction and an optional add of the first operand each cycle (Horner form). After XLEN such cycles it presents the result and pulses `done_o`.

The controller has three states. IDLE waits for `start_i` (transition IDLE to RUN, capturing the inputs). RUN does one step per cycle and moves to FINISH after its XLEN-th step, writing `result_o` on that edge. FINISH raises `done_o` for exactly one cycle and always returns to IDLE. Requests that arrive in RUN or FINISH are dropped.

Top module: `gf_mul_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `done_o` is 0 and `result_o` is 0.
- R2: With `op_i` = 2'b00 the result is A·B mod g(x) over GF(2), where g(x) = x^m + (the lower m bits of `modulus_i`); bits of `modulus_i` at or above m are ignored, so supplying the x^m bit or leaving it out gives the same result.
- R3: With `op_i` = 2'b00, operand bits at or above position m have no effect, and every result bit at or above m is 0.
- R4: With `op_i` = 2'b01 the result is bits XLEN-1..0 of the full carry-less product of A and B.
- R5: With `op_i` = 2'b10 the result is bits 2·XLEN-1..XLEN of the full carry-less product.
- R6: With `op_i` = 2'b11 the result is bits 2·XLEN-2..XLEN-1 of the full carry-less product.
- R7: `done_o` is a one-cycle pulse that is high in the XLEN-th cycle after the edge that accepts `start_i`; `result_o` changes only on the edge that raises `done_o` and holds its value until the next completion.
- R8: `start_i` is ignored in RUN and FINISH: the running request completes on time with its own result and no extra completion follows.
- R9: A `degree_i` above XLEN is treated as XLEN; a `degree_i` of 0 gives a result of 0 for `op_i` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted only in IDLE |
| op_i | input | 2 | 00 field multiply, 01 low word, 10 high word, 11 shifted-high word |
| degree_i | input | $clog2(XLEN+1) | Field degree m |
| modulus_i | input | XLEN | Reduction polynomial; lower m bits used |
| opa_i | input | XLEN | Operand A |
| opb_i | input | XLEN | Operand B |
| result_o | output | XLEN | Result, valid from the `done_o` cycle on |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the two known small-field products, a full 64-degree field with top bits set in both operands, and operands dirtied above m; a design that tested the wrong bit for reduction, or forgot to mask operands, returns a value that differs from the independent long-division model. The three carry-less windows are checked with all-ones and sparse operands so that an off-by-one in the shifted-high window, or a swapped high and low word, shows as a single bit moved. Latency is counted edge by edge and a second start is thrown in mid-run, so a unit that finished a cycle early, restarted on the stray strobe, or produced a second pulse is reported. Degree clamping and degree zero catch a mask generator that wraps or indexes out of range.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;

    typedef enum logic [1:0] {
        OP_FIELD = 2'b00,
        OP_LOW   = 2'b01,
        OP_HIGH  = 2'b10,
        OP_SHIFT = 2'b11
    } gf_op_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RUN    = 2'b01,
        ST_FINISH = 2'b10
    } gf_state_t;

endpackage

// File: rtl/gf_operand_prep.sv
module gf_operand_prep #(
    parameter int XLEN  = 64,
    parameter int DEG_W = $clog2(XLEN + 1)
) (
    input  logic [DEG_W-1:0] degree_i,
    input  logic [XLEN-1:0]  modulus_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    output logic [DEG_W-1:0] deg_eff_o,
    output logic [XLEN-1:0]  mask_o,
    output logic [XLEN-1:0]  opa_m_o,
    output logic [XLEN-1:0]  opb_m_o,
    output logic [XLEN-1:0]  poly_m_o
);

    localparam logic [DEG_W-1:0] DEG_MAX = DEG_W'(XLEN);

    // clamp degrees beyond the word to the word width
    always_comb begin
        if (degree_i > DEG_MAX) begin
            deg_eff_o = DEG_MAX;
        end else begin
            deg_eff_o = degree_i;
        end
    end

    // one comparator per bit builds the below-degree mask
    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        assign mask_o[i] = (DEG_W'(i) < deg_eff_o);
    end

    assign opa_m_o  = opa_i & mask_o;
    assign opb_m_o  = opb_i & mask_o;
    assign poly_m_o = modulus_i & mask_o;

endmodule

// File: rtl/gf_horner_step.sv
module gf_horner_step #(
    parameter int XLEN  = 64,
    parameter int DEG_W = $clog2(XLEN + 1),
    parameter int ACC_W = 2 * XLEN
) (
    input  logic             field_en_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic             b_bit_i,
    input  logic [XLEN-1:0]  poly_i,
    input  logic [XLEN-1:0]  mask_i,
    input  logic [DEG_W-1:0] deg_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] shifted;
    logic             reduce;
    logic [XLEN-1:0]  field_next;
    logic [XLEN-1:0]  addend;

    always_comb begin
        shifted = acc_i << 1;
        // coefficient of x^m after the shift decides reduction
        reduce  = shifted[deg_i];
        addend  = b_bit_i ? opa_i : '0;
        field_next = (shifted[XLEN-1:0] & mask_i)
                   ^ (reduce ? poly_i : '0)
                   ^ addend;
        if (field_en_i) begin
            acc_o = {{XLEN{1'b0}}, field_next};
        end else begin
            acc_o = shifted ^ {{XLEN{1'b0}}, addend};
        end
    end

endmodule

// File: rtl/gf_result_sel.sv
module gf_result_sel
    import gf_mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int ACC_W = 2 * XLEN
) (
    input  gf_op_t           op_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [XLEN-1:0]  res_o
);

    always_comb begin
        unique case (op_i)
            OP_FIELD: res_o = acc_i[XLEN-1:0];
            OP_LOW:   res_o = acc_i[XLEN-1:0];
            OP_HIGH:  res_o = acc_i[ACC_W-1:XLEN];
            OP_SHIFT: res_o = acc_i[ACC_W-2:XLEN-1];
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/gf_mul_unit.sv
module gf_mul_unit
    import gf_mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int DEG_W = $clog2(XLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [DEG_W-1:0] degree_i,
    input  logic [XLEN-1:0]  modulus_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    output logic [XLEN-1:0]  result_o,
    output logic             done_o
);

    localparam int ACC_W = 2 * XLEN;
    localparam int CNT_W = $clog2(XLEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XLEN - 1);

    gf_state_t state_q, state_d;

    gf_op_t           op_q;
    logic [DEG_W-1:0] deg_q;
    logic [XLEN-1:0]  mask_q;
    logic [XLEN-1:0]  opa_q;
    logic [XLEN-1:0]  opb_q;
    logic [XLEN-1:0]  poly_q;
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [XLEN-1:0]  result_q;

    logic [DEG_W-1:0] deg_eff;
    logic [XLEN-1:0]  mask_c;
    logic [XLEN-1:0]  opa_m;
    logic [XLEN-1:0]  opb_m;
    logic [XLEN-1:0]  poly_m;
    logic [ACC_W-1:0] acc_next;
    logic [XLEN-1:0]  res_sel;
    logic             accept;
    logic             last_step;
    logic             field_in;

    gf_operand_prep #(.XLEN(XLEN), .DEG_W(DEG_W)) prep_i (
        .degree_i  (degree_i),
        .modulus_i (modulus_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .deg_eff_o (deg_eff),
        .mask_o    (mask_c),
        .opa_m_o   (opa_m),
        .opb_m_o   (opb_m),
        .poly_m_o  (poly_m)
    );

    gf_horner_step #(.XLEN(XLEN), .DEG_W(DEG_W), .ACC_W(ACC_W)) step_i (
        .field_en_i (op_q == OP_FIELD),
        .acc_i      (acc_q),
        .opa_i      (opa_q),
        .b_bit_i    (opb_q[XLEN-1]),
        .poly_i     (poly_q),
        .mask_i     (mask_q),
        .deg_i      (deg_q),
        .acc_o      (acc_next)
    );

    gf_result_sel #(.XLEN(XLEN), .ACC_W(ACC_W)) sel_i (
        .op_i  (op_q),
        .acc_i (acc_next),
        .res_o (res_sel)
    );

    assign accept    = start_i && (state_q == ST_IDLE);
    assign last_step = (state_q == ST_RUN) && (cnt_q == CNT_LAST);
    assign field_in  = (gf_op_t'(op_i) == OP_FIELD);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RUN;
            ST_RUN:    if (cnt_q == CNT_LAST) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_FIELD;
            deg_q    <= '0;
            mask_q   <= '0;
            opa_q    <= '0;
            opb_q    <= '0;
            poly_q   <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
            result_q <= '0;
        end else if (accept) begin
            op_q   <= gf_op_t'(op_i);
            deg_q  <= deg_eff;
            mask_q <= mask_c;
            opa_q  <= field_in ? opa_m : opa_i;
            opb_q  <= field_in ? opb_m : opb_i;
            poly_q <= poly_m;
            acc_q  <= '0;
            cnt_q  <= '0;
        end else if (state_q == ST_RUN) begin
            acc_q <= acc_next;
            opb_q <= opb_q << 1;
            cnt_q <= cnt_q + 1'b1;
            if (last_step) begin
                result_q <= res_sel;
            end
        end
    end

    // outputs
    always_comb begin
        done_o   = (state_q == ST_FINISH);
        result_o = result_q;
    end

endmodule

// File: rtl/gf_mul_unit_chk.sv
module gf_mul_unit_chk
    import gf_mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int DEG_W = $clog2(XLEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       op_i,
    input logic [DEG_W-1:0] degree_i,
    input logic [XLEN-1:0]  result_o,
    input logic             done_o,
    input gf_state_t        state_q
);

    localparam int LAT_W = $clog2(XLEN + 2) + 1;
    localparam logic [LAT_W-1:0] LAT_DONE = LAT_W'(XLEN);
    localparam logic [LAT_W-1:0] LAT_SAT  = LAT_W'(XLEN + 1);

    logic [LAT_W-1:0] lat_q;
    logic [1:0]       op_l;
    logic [DEG_W-1:0] deg_l;
    logic [XLEN-1:0]  hi_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= LAT_SAT;
            op_l  <= '0;
            deg_l <= '0;
        end else if (start_i && state_q == ST_IDLE) begin
            lat_q <= '0;
            op_l  <= op_i;
            deg_l <= (degree_i > DEG_W'(XLEN)) ? DEG_W'(XLEN) : degree_i;
        end else if (lat_q < LAT_SAT) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    always_comb begin
        if (deg_l >= DEG_W'(XLEN)) begin
            hi_mask = '0;
        end else begin
            hi_mask = ~((XLEN'(1) << deg_l) - XLEN'(1));
        end
    end

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == LAT_DONE));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> $rose(done_o));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && lat_q < LAT_W'(XLEN - 1)) |=> (state_q == ST_RUN));

    // R3
    field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_l == 2'b00) |-> ((result_o & hi_mask) == '0));

endmodule

bind gf_mul_unit gf_mul_unit_chk #(.XLEN(XLEN), .DEG_W(DEG_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .degree_i (degree_i),
    .result_o (result_o),
    .done_o   (done_o),
    .state_q  (state_q)
);

// File: tb/gf_mul_unit_tb_top.sv
module gf_mul_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 64;
    localparam int DEG_W = $clog2(XLEN + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [1:0]       op_i = '0;
    logic [DEG_W-1:0] degree_i = '0;
    logic [XLEN-1:0]  modulus_i = '0;
    logic [XLEN-1:0]  opa_i = '0;
    logic [XLEN-1:0]  opb_i = '0;
    logic [XLEN-1:0]  result_o;
    logic             done_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gf_mul_unit #(.XLEN(XLEN)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .degree_i  (degree_i),
        .modulus_i (modulus_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .result_o  (result_o),
        .done_o    (done_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_clmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] p = '0;
        for (int i = 0; i < 64; i++) begin
            if (b[i]) p = p ^ ({64'd0, a} << i);
        end
        return p;
    endfunction

    function automatic logic [63:0] ref_field(input logic [63:0] a, input logic [63:0] b,
                                              input int deg, input logic [63:0] poly);
        int m = (deg > 64) ? 64 : deg;
        logic [127:0] mk, p, g;
        if (m == 0) return 64'd0;
        mk = (128'd1 << m) - 128'd1;
        p  = ref_clmul(a & mk[63:0], b & mk[63:0]);
        g  = ({64'd0, poly} & mk) | (128'd1 << m);
        for (int i = 126; i >= m; i--) begin
            if (p[i]) p = p ^ (g << (i - m));
        end
        return p[63:0];
    endfunction

    // issue one request; lat counts edges from acceptance to done
    task automatic run_op(input logic [1:0] op, input int deg, input logic [63:0] poly,
                          input logic [63:0] a, input logic [63:0] b, input bit meddle,
                          output logic [63:0] res, output int lat);
        @(negedge clk);
        op_i = op; degree_i = DEG_W'(deg); modulus_i = poly;
        opa_i = a; opb_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 300) begin
            if (meddle && lat == 10) begin
                start_i = 1'b1; op_i = 2'b01; opa_i = ~a; opb_i = ~b;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        res = result_o;
    endtask

    task automatic test_reset();
        check("R1 done in reset", {63'd0, done_o}, 64'd0);
        check("R1 result in reset", result_o, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {63'd0, done_o}, 64'd0);
        check("R1 result after reset", result_o, 64'd0);
    endtask

    task automatic test_small_fields();
        logic [63:0] r; int l;
        run_op(2'b00, 3, 64'hB, 64'h7, 64'h5, 1'b0, r, l);
        check("R2 gf8 7*5", r, 64'h6);
        run_op(2'b00, 8, 64'h11B, 64'h80, 64'h83, 1'b0, r, l);
        check("R2 gf256 80*83", r, 64'h01);
        run_op(2'b00, 8, 64'h01B, 64'h80, 64'h83, 1'b0, r, l);
        check("R2 top bit omitted", r, 64'h01);
        run_op(2'b00, 8, 64'h11B, 64'h57, 64'h83, 1'b0, r, l);
        check("R2 gf256 57*83", r, ref_field(64'h57, 64'h83, 8, 64'h11B));
    endtask

    task automatic test_wide_field();
        logic [63:0] r; int l;
        logic [63:0] a = 64'hF00D_CAFE_1234_8765;
        logic [63:0] b = 64'h8BAD_F00D_DEAD_BEEF;
        run_op(2'b00, 64, 64'h1B, a, b, 1'b0, r, l);
        check("R2 degree 64", r, ref_field(a, b, 64, 64'h1B));
        run_op(2'b00, 100, 64'h1B, a, b, 1'b0, r, l);
        check("R9 degree clamp", r, ref_field(a, b, 64, 64'h1B));
        run_op(2'b00, 0, 64'h1B, a, b, 1'b0, r, l);
        check("R9 degree zero", r, 64'd0);
    endtask

    task automatic test_masking();
        logic [63:0] r; int l;
        run_op(2'b00, 8, 64'h11B, 64'hFFFF_FF00_0000_0053, 64'hABCD_0000_0000_00CA,
               1'b0, r, l);
        check("R3 high operand bits ignored", r, 64'h01);
        run_op(2'b00, 13, 64'h201B, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555,
               1'b0, r, l);
        check("R3 result below 2^m", r & ~64'h1FFF, 64'd0);
        check("R3 value", r, ref_field(64'h1FFF, 64'h1555, 13, 64'h201B));
    endtask

    task automatic test_carryless();
        logic [63:0] r; int l;
        logic [127:0] p;
        logic [63:0] a, b;
        for (int k = 0; k < 3; k++) begin
            a = (k == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : (k == 1) ? 64'h8000_0000_0000_0001
                                                             : 64'h0123_4567_89AB_CDEF;
            b = (k == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : (k == 1) ? 64'h8000_0000_0000_0003
                                                             : 64'hFEDC_BA98_7654_3210;
            p = ref_clmul(a, b);
            run_op(2'b01, 5, 64'h25, a, b, 1'b0, r, l);
            check("R4 low word", r, p[63:0]);
            run_op(2'b10, 5, 64'h25, a, b, 1'b0, r, l);
            check("R5 high word", r, p[127:64]);
            run_op(2'b11, 5, 64'h25, a, b, 1'b0, r, l);
            check("R6 shifted word", r, p[126:63]);
        end
    endtask

    task automatic test_timing();
        logic [63:0] r; int l;
        run_op(2'b01, 64, 64'h0, 64'h3, 64'h5, 1'b0, r, l);
        check("R7 latency", 64'(l), 64'(XLEN));
        check("R7 result on done", r, 64'hF);
        @(negedge clk);
        check("R7 done is a pulse", {63'd0, done_o}, 64'd0);
        check("R7 result held", result_o, 64'hF);
    endtask

    task automatic test_busy_start();
        logic [63:0] r; int l; int extra = 0;
        run_op(2'b00, 8, 64'h11B, 64'h80, 64'h83, 1'b1, r, l);
        check("R8 latency with stray start", 64'(l), 64'(XLEN));
        check("R8 result of first request", r, 64'h01);
        for (int i = 0; i < XLEN + 4; i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check("R8 no second completion", 64'(extra), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_small_fields();
        test_wide_field();
        test_masking();
        test_carryless();
        test_timing();
        test_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule